// File: doc/BRIEF.md
# Extended Stack Pointer Unit

This block holds the stack pointer of an 8051-class processor core. The pointer has a low byte and a 3-bit extension kept in a separate high register. Together they form an 11-bit pointer. The core sends one stack command for each byte it moves: push, pop, call or return. The block answers with the address of that byte and a select line. The select line tells the memory side whether the byte lives in the 256-byte internal RAM or in the on-chip extended RAM.

A configuration bit picks the mode. With the bit clear, the pointer behaves like a classic 8-bit stack pointer: it wraps inside internal RAM and the extension is hidden. With the bit set, the full 11-bit pointer is used. Pushing past the top of internal RAM carries into extended RAM at 100h, and popping back below 100h returns to internal RAM. Software reads and writes the low register, the high register and the configuration register through a byte-wide register port.

Top module: `xsp_top`

## Requirements
- R1: After synchronous reset the low pointer register reads 07h, the high register reads 00h and the configuration register reads 00h, so the first push uses address 008h.
- R2: A push (op_kind 00) first adds one to the pointer, then performs the write access. One cycle later stk_wr pulses and stk_addr shows the incremented pointer, which is also the new pointer value.
- R3: A pop (op_kind 01) reads at the current pointer, then subtracts one from it. One cycle later stk_rd pulses and stk_addr shows the pre-decrement pointer.
- R4: With the mode bit clear, only the low byte moves. It wraps from FFh to 00h on increment and from 00h to FFh on decrement. The upper three bits of stk_addr are zero, and the high register keeps its value.
- R5: With the mode bit set, the 11-bit pointer moves as one value. 0FFh increments to 100h, 100h decrements to 0FFh, 7FFh increments to 000h, and 000h decrements to 7FFh.
- R6: stk_xsel is 1 exactly when the stk_addr it comes with lies in 100h..7FFh, and 0 for 000h..0FFh.
- R7: The registers are mapped as follows. The low pointer is at 81h. The high register is at B7h, with the extension in bits 2:0 and bits 7:3 reading 0. The mode bit is bit 7 of the register at AFh, whose other bits read 0. Any other address reads 00h. A read returns, one cycle later on reg_rdata, the value before any update in the same cycle.
- R8: While the mode bit is clear, writes to B7h are ignored and reads of B7h return 00h.
- R9: When a write to 81h or B7h lands in the same cycle as a stack command, the access address still comes from the old pointer. The pointer then takes the written value instead of the stepped one.
- R10: A call (op_kind 10) behaves exactly as a push, and a return (op_kind 11) behaves exactly as a pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | One stack byte command this cycle |
| op_kind | input | 2 | 00 push, 01 pop, 10 call, 11 return |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, held between reads |
| stk_addr | output | 11 | Address of the last stack byte access |
| stk_xsel | output | 1 | 1 selects extended RAM, 0 internal RAM |
| stk_wr | output | 1 | Write access pulse (push or call) |
| stk_rd | output | 1 | Read access pulse (pop or return) |

## Verification
Several properties are checked on every cycle. These are the reset values, the FFh-to-00h wrap in classic mode, the carry from 0FFh into 100h in extended mode, the lock on the high register while the mode is off, the internal-only select in classic mode, the zero read of the hidden register, and the pop address. Other behaviour can only be shown by the bench's scenarios, where the bench reads the registers back after a chosen sequence. These are the interplay of mode switching with a stale extension value, the write-versus-command priority, the 7FFh and 000h wraps, and long mixed random command streams checked against a reference model.

// File: rtl/xsp_pkg.sv
package xsp_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'b00,
    OP_POP  = 2'b01,
    OP_CALL = 2'b10,
    OP_RET  = 2'b11
  } stk_op_e;

  // Push and call pre-increment; pop and return post-decrement (R10).
  function automatic logic op_is_inc(input logic [1:0] kind);
    stk_op_e k;
    k = stk_op_e'(kind);
    return (k == OP_PUSH) || (k == OP_CALL);
  endfunction
endpackage

// File: rtl/xsp_cfg.sv
module xsp_cfg #(
  parameter int          AW       = 8,
  parameter logic [7:0]  CFG_ADDR = 8'hAF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic          en_wdata,
  output logic          ext_en
);
  always_ff @(posedge clk) begin
    if (rst)
      ext_en <= 1'b0;
    else if (reg_wr && reg_addr == CFG_ADDR[AW-1:0])
      ext_en <= en_wdata;
  end

  // R1: mode bit clears on reset
  p_cfg_reset_r1: assert property (@(posedge clk) rst |=> !ext_en)
    else $error("p_cfg_reset_r1");
endmodule

// File: rtl/xsp_ptr.sv
module xsp_ptr
  import xsp_pkg::*;
#(
  parameter int         DATA_W  = 8,
  parameter int         HI_W    = 3,
  parameter int         AW      = 8,
  parameter logic [7:0] LO_ADDR = 8'h81,
  parameter logic [7:0] HI_ADDR = 8'hB7,
  parameter logic [DATA_W-1:0] LO_RST = 8'h07,
  localparam int        PTR_W   = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_en,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              reg_wr,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] lo_q,
  output logic [HI_W-1:0]   hi_q,
  output logic [PTR_W-1:0]  acc_addr,
  output logic              acc_inc
);
  logic [PTR_W-1:0]  cur;
  logic [PTR_W-1:0]  nxt_ext;
  logic [DATA_W-1:0] nxt_lo;
  logic              wr_lo, wr_hi, sw_wr;

  always_comb begin
    acc_inc = op_is_inc(op_kind);
    cur     = ext_en ? {hi_q, lo_q} : {{HI_W{1'b0}}, lo_q};
    nxt_ext = acc_inc ? cur + PTR_W'(1) : cur - PTR_W'(1);
    nxt_lo  = acc_inc ? lo_q + DATA_W'(1) : lo_q - DATA_W'(1);
    if (!acc_inc)
      acc_addr = cur;
    else if (ext_en)
      acc_addr = nxt_ext;
    else
      acc_addr = {{HI_W{1'b0}}, nxt_lo};
    wr_lo = reg_wr && reg_addr == LO_ADDR[AW-1:0];
    wr_hi = reg_wr && reg_addr == HI_ADDR[AW-1:0] && ext_en;
    sw_wr = wr_lo || wr_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= LO_RST;
      hi_q <= '0;
    end else if (sw_wr) begin
      if (wr_lo) lo_q <= reg_wdata;
      if (wr_hi) hi_q <= reg_wdata[HI_W-1:0];
    end else if (op_valid) begin
      if (ext_en) {hi_q, lo_q} <= nxt_ext;
      else        lo_q <= nxt_lo;
    end
  end

  // R1: reset values of the pointer
  p_ptr_reset_r1: assert property (@(posedge clk)
    rst |=> (lo_q == LO_RST && hi_q == '0))
    else $error("p_ptr_reset_r1");

  // R8 / R4: extension cannot change while the mode bit is clear
  p_hi_locked_r8: assert property (@(posedge clk) disable iff (rst)
    !ext_en |=> $stable(hi_q))
    else $error("p_hi_locked_r8");

  // R4: classic increment wraps FFh to 00h
  p_classic_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && acc_inc && !ext_en && !sw_wr && lo_q == '1) |=> lo_q == '0)
    else $error("p_classic_wrap_r4");

  // R5: extended increment carries from 0FFh into 100h
  p_ext_carry_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && acc_inc && ext_en && !sw_wr && hi_q == '0 && lo_q == '1)
      |=> (hi_q == HI_W'(1) && lo_q == '0))
    else $error("p_ext_carry_r5");
endmodule

// File: rtl/xsp_port.sv
module xsp_port #(
  parameter int         DATA_W   = 8,
  parameter int         HI_W     = 3,
  parameter int         AW       = 8,
  parameter logic [7:0] LO_ADDR  = 8'h81,
  parameter logic [7:0] HI_ADDR  = 8'hB7,
  parameter logic [7:0] CFG_ADDR = 8'hAF,
  parameter int         EN_BIT   = 7,
  localparam int        PTR_W    = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_en,
  input  logic [DATA_W-1:0] lo_q,
  input  logic [HI_W-1:0]   hi_q,
  input  logic [PTR_W-1:0]  acc_addr,
  input  logic              acc_inc,
  input  logic              op_valid,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [PTR_W-1:0]  stk_addr,
  output logic              stk_xsel,
  output logic              stk_wr,
  output logic              stk_rd
);
  localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << EN_BIT;
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    if (reg_addr == LO_ADDR[AW-1:0])
      rd_mux = lo_q;
    else if (reg_addr == HI_ADDR[AW-1:0] && ext_en)
      rd_mux = {{(DATA_W-HI_W){1'b0}}, hi_q};
    else if (reg_addr == CFG_ADDR[AW-1:0])
      rd_mux = ext_en ? EN_MASK : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      stk_addr  <= '0;
      stk_xsel  <= 1'b0;
      stk_wr    <= 1'b0;
      stk_rd    <= 1'b0;
    end else begin
      if (reg_rd) reg_rdata <= rd_mux;
      if (op_valid) begin
        stk_addr <= acc_addr;
        stk_xsel <= |acc_addr[PTR_W-1:DATA_W];
      end
      stk_wr <= op_valid && acc_inc;
      stk_rd <= op_valid && !acc_inc;
    end
  end

  // R6: classic mode never selects extended RAM
  p_classic_int_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !ext_en) |=> !stk_xsel)
    else $error("p_classic_int_r6");

  // R8: hidden high register reads as zero
  p_hidden_read_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == HI_ADDR[AW-1:0] && !ext_en) |=> reg_rdata == '0)
    else $error("p_hidden_read_r8");

  // R3: a classic pop reads at the current low pointer
  p_pop_addr_r3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !acc_inc && !ext_en)
      |=> (stk_rd && stk_addr[DATA_W-1:0] == $past(lo_q)))
    else $error("p_pop_addr_r3");
endmodule

// File: rtl/xsp_top.sv
module xsp_top #(
  parameter int         DATA_W   = 8,
  parameter int         HI_W     = 3,
  parameter logic [7:0] LO_ADDR  = 8'h81,
  parameter logic [7:0] HI_ADDR  = 8'hB7,
  parameter logic [7:0] CFG_ADDR = 8'hAF,
  parameter int         EN_BIT   = 7,
  parameter logic [DATA_W-1:0] LO_RST = 8'h07,
  localparam int        AW       = 8,
  localparam int        PTR_W    = DATA_W + HI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [1:0]        op_kind,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [PTR_W-1:0]  stk_addr,
  output logic              stk_xsel,
  output logic              stk_wr,
  output logic              stk_rd
);
  logic              ext_en;
  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [PTR_W-1:0]  acc_addr;
  logic              acc_inc;

  xsp_cfg #(.AW(AW), .CFG_ADDR(CFG_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .en_wdata(reg_wdata[EN_BIT]), .ext_en(ext_en)
  );

  xsp_ptr #(.DATA_W(DATA_W), .HI_W(HI_W), .AW(AW), .LO_ADDR(LO_ADDR),
            .HI_ADDR(HI_ADDR), .LO_RST(LO_RST)) u_ptr (
    .clk(clk), .rst(rst), .ext_en(ext_en), .op_valid(op_valid),
    .op_kind(op_kind), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .lo_q(lo_q), .hi_q(hi_q),
    .acc_addr(acc_addr), .acc_inc(acc_inc)
  );

  xsp_port #(.DATA_W(DATA_W), .HI_W(HI_W), .AW(AW), .LO_ADDR(LO_ADDR),
             .HI_ADDR(HI_ADDR), .CFG_ADDR(CFG_ADDR), .EN_BIT(EN_BIT)) u_port (
    .clk(clk), .rst(rst), .ext_en(ext_en), .lo_q(lo_q), .hi_q(hi_q),
    .acc_addr(acc_addr), .acc_inc(acc_inc), .op_valid(op_valid),
    .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
    .stk_addr(stk_addr), .stk_xsel(stk_xsel), .stk_wr(stk_wr), .stk_rd(stk_rd)
  );
endmodule

// File: tb/sim_xsp_top.sv
module sim_xsp_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [1:0]  op_kind;
  logic        reg_wr, reg_rd;
  logic [7:0]  reg_addr, reg_wdata;
  logic [7:0]  reg_rdata;
  logic [10:0] stk_addr;
  logic        stk_xsel, stk_wr, stk_rd;

  int checks = 0;
  int errors = 0;

  // reference model state
  logic [7:0]  m_lo, m_hi_d, m_rdata;
  logic [2:0]  m_hi;
  logic        m_en;
  logic [10:0] m_addr;
  logic        m_xsel;

  always #(CLK_PERIOD/2) clk = ~clk;

  xsp_top u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .stk_addr(stk_addr),
    .stk_xsel(stk_xsel), .stk_wr(stk_wr), .stk_rd(stk_rd)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] f_read(input logic [7:0] a);
    if (a == 8'h81) return m_lo;
    if (a == 8'hB7) return m_en ? {5'b0, m_hi} : 8'h00;
    if (a == 8'hAF) return m_en ? 8'h80 : 8'h00;
    return 8'h00;
  endfunction

  function automatic logic [10:0] f_addr(input logic inc);
    logic [10:0] cur;
    cur = m_en ? {m_hi, m_lo} : {3'b0, m_lo};
    if (!inc) return cur;
    if (m_en) return cur + 11'd1;
    return {3'b0, m_lo + 8'd1};
  endfunction

  // One cycle of stimulus; model updated and all outputs checked.
  task automatic step(input logic ov, input logic [1:0] kind, input logic wr,
                      input logic rd, input logic [7:0] a, input logic [7:0] wd,
                      input string tag);
    logic inc, sw;
    logic [10:0] nxt;
    @(negedge clk);
    op_valid = ov; op_kind = kind; reg_wr = wr; reg_rd = rd;
    reg_addr = a; reg_wdata = wd;
    inc = (kind == 2'b00) || (kind == 2'b10);
    if (rd) m_rdata = f_read(a);
    if (ov) begin
      m_addr = f_addr(inc);
      m_xsel = (m_addr >= 11'h100);
    end
    sw = wr && (a == 8'h81 || (a == 8'hB7 && m_en));
    if (sw) begin
      if (a == 8'h81) m_lo = wd;
      else m_hi = wd[2:0];
    end else if (ov) begin
      if (m_en) begin
        nxt = inc ? {m_hi, m_lo} + 11'd1 : {m_hi, m_lo} - 11'd1;
        {m_hi, m_lo} = nxt;
      end else begin
        m_lo = inc ? m_lo + 8'd1 : m_lo - 8'd1;
      end
    end
    if (wr && a == 8'hAF) m_en = wd[7];
    @(posedge clk);
    #1;
    op_valid = 0; reg_wr = 0; reg_rd = 0;
    chk(reg_rdata == m_rdata, {tag, " rdata"}, reg_rdata, m_rdata);
    chk(stk_addr == m_addr, {tag, " addr"}, stk_addr, m_addr);
    chk(stk_xsel == m_xsel, {tag, " R6 xsel"}, stk_xsel, m_xsel);
    chk(stk_wr == (ov && inc), {tag, " wr"}, stk_wr, ov && inc);
    chk(stk_rd == (ov && !inc), {tag, " rd"}, stk_rd, ov && !inc);
  endtask

  task automatic op(input logic [1:0] kind, input string tag);
    step(1'b1, kind, 1'b0, 1'b0, 8'h00, 8'h00, tag);
  endtask
  task automatic wreg(input logic [7:0] a, input logic [7:0] d, input string tag);
    step(1'b0, 2'b00, 1'b1, 1'b0, a, d, tag);
  endtask
  task automatic rreg(input logic [7:0] a, input logic [7:0] exp, input string tag);
    step(1'b0, 2'b00, 1'b0, 1'b1, a, 8'h00, tag);
    chk(reg_rdata == exp, {tag, " directed"}, reg_rdata, exp);
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst = 1; op_valid = 0; op_kind = 0; reg_wr = 0; reg_rd = 0;
    reg_addr = 0; reg_wdata = 0;
    m_lo = 8'h07; m_hi = 0; m_en = 0; m_rdata = 0; m_addr = 0; m_xsel = 0;
    m_hi_d = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    rreg(8'h81, 8'h07, "R1 low reset");
    rreg(8'hAF, 8'h00, "R1 cfg reset");
    rreg(8'hB7, 8'h00, "R1 high reset");
    op(2'b00, "R1 R2 first push");
    chk(stk_addr == 11'h008, "R1 first push at 008", stk_addr, 11'h008);
    op(2'b10, "R10 call");
    chk(stk_addr == 11'h009, "R10 call as push", stk_addr, 11'h009);
    op(2'b01, "R3 pop");
    chk(stk_addr == 11'h009 && stk_rd, "R3 pop address", stk_addr, 11'h009);
    op(2'b11, "R10 ret");
    rreg(8'h81, 8'h07, "R3 R10 pointer restored");

    // R4 classic wrap
    wreg(8'h81, 8'hFF, "R4 set FF");
    op(2'b00, "R4 push wraps");
    chk(stk_addr == 11'h000, "R4 FF to 00", stk_addr, 11'h000);
    op(2'b01, "R4 pop at 00");
    rreg(8'h81, 8'hFF, "R4 00 to FF");

    // R8 hidden high register
    wreg(8'hB7, 8'h05, "R8 write ignored");
    wreg(8'hAF, 8'h80, "R7 enable");
    rreg(8'hB7, 8'h00, "R8 write was dropped");
    rreg(8'hAF, 8'h80, "R7 cfg bit 7");
    rreg(8'h55, 8'h00, "R7 unmapped");

    // R5/R6 carry into extended RAM
    op(2'b00, "R5 push 0FF");
    chk(stk_addr == 11'h100 && stk_xsel, "R5 R6 carry to 100", stk_addr, 11'h100);
    rreg(8'hB7, 8'h01, "R5 high 01");
    rreg(8'h81, 8'h00, "R5 low 00");
    op(2'b01, "R5 pop 100");
    op(2'b01, "R5 pop 0FF");
    chk(stk_addr == 11'h0FF && !stk_xsel, "R6 back to internal", stk_addr, 11'h0FF);

    // R5 top-end wraps
    wreg(8'hB7, 8'hFF, "R7 high write");
    rreg(8'hB7, 8'h07, "R7 upper bits zero");
    wreg(8'h81, 8'hFF, "R5 set 7FF");
    op(2'b00, "R5 7FF to 000");
    chk(stk_addr == 11'h000 && !stk_xsel, "R5 wrap 000", stk_addr, 11'h000);
    op(2'b01, "R5 pop 000");
    op(2'b01, "R5 pop 7FF");
    chk(stk_addr == 11'h7FF && stk_xsel, "R5 000 to 7FF", stk_addr, 11'h7FF);

    // R9 write wins over same-cycle command
    step(1'b1, 2'b00, 1'b1, 1'b0, 8'h81, 8'h40, "R9 write with push");
    rreg(8'h81, 8'h40, "R9 written value kept");

    // R4 back to classic with stale extension
    wreg(8'hAF, 8'h00, "R4 disable");
    op(2'b00, "R4 classic push");
    chk(stk_addr == 11'h041 && !stk_xsel, "R4 upper bits zero", stk_addr, 11'h041);
    rreg(8'hB7, 8'h00, "R8 hidden again");

    // random mix
    for (int i = 0; i < 600; i++) begin
      int sel;
      logic [7:0] a;
      sel = $urandom % 10;
      case ($urandom % 4)
        0: a = 8'h81;
        1: a = 8'hB7;
        2: a = 8'hAF;
        default: a = 8'($urandom);
      endcase
      if (sel < 6)
        op(2'($urandom), "R2 R3 R10 random op");
      else if (sel < 8)
        step($urandom % 3 == 0, 2'($urandom), 1'b1, 1'b0, a, 8'($urandom),
             "R9 random write");
      else
        step($urandom % 2 == 0, 2'($urandom), 1'b0, 1'b1, a, 8'h00,
             "R7 random read");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule